// File: doc/BRIEF.md
# SDRAM Mode Register Programming Unit

This block lives on the memory side of an SDRAM command bus and captures the writes that program the device's operating modes. On every rising clock it samples the active-low command lines, the two bank-address bits and the 13-bit address bus. It recognises the register-write command and holds two registers. The main register sets burst length, burst ordering and CAS latency. The extended register sets the self-refresh array portion and the output drive strength. It presents these settings in decoded form for the rest of the memory model.

A register write needs two cycles to settle. For the two command edges after an accepted write, `busy` is high and every command seen at those edges is dropped and reported. A write is accepted only while the bank tracker reports all banks idle. A write that holds a reserved code or a nonzero must-be-zero bit still takes effect, but it latches a sticky error that software clears through `err_clear`. All pins are plain control and status; the block has no streaming interface.

Top module: `sdram_mode_ctl`

## Requirements
- R1: A register-write command is cs_n, ras_n, cas_n and we_n all low at a rising edge. Bank address 2'b00 targets the main register and 2'b10 (bit 1 high, bit 0 low) targets the extended register. Bank address 2'b01 or 2'b11 changes no register and starts no busy window.
- R2: The main register's addr[2:0] sets burst_len to 2, 4, 8 or 16 for codes 001, 010, 011 and 100. Every other code reads as burst_len 0.
- R3: The main register's addr[3] drives burst_interleave: 0 selects sequential ordering and 1 selects interleaved ordering.
- R4: The main register's addr[6:4] sets cas_latency to 2 for code 010 and to 3 for code 011. Every other code reads as cas_latency 0.
- R5: An extended write copies addr[2:0] to refresh_portion (000 full, 001 half, 010 quarter, others reserved). It copies addr[6:5] to drive_strength (00 full, 01 half, 10 quarter, 11 eighth).
- R6: After reset, refresh_portion is 000 and drive_strength is 01. mode_valid, burst_len, cas_latency, burst_interleave, busy and all error outputs are 0.
- R7: An accepted main-register write also returns the extended register to refresh_portion 000 and drive_strength 01.
- R8: After an accepted write, busy is high for exactly two cycles. Any command at the two edges sampled while busy is high has no effect on any register. A command is cs_n low with ras_n, cas_n and we_n not all high. Each such command pulses protocol_error for one cycle after its edge.
- R9: A register write while banks_idle is low has no effect and starts no busy window. It pulses write_reject for one cycle after its edge.
- R10: An accepted write with a reserved code or a nonzero must-be-zero bit still updates its register and sets config_error. Reserved codes are burst length, CAS latency or array portion codes outside the lists above. Must-be-zero bits are addr[12:7] for both registers and addr[4:3] for the extended register. config_error stays set until err_clear is high at an edge. A new error at the same edge as err_clear keeps the flag set.
- R11: mode_valid is low until the first accepted main-register write and then stays high. While mode_valid is low, burst_len, cas_latency and burst_interleave read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, selects the target register |
| addr | input | ADDR_W | Address bus, carries the register contents |
| banks_idle | input | 1 | High when every bank is precharged |
| err_clear | input | 1 | Clears config_error |
| mode_valid | output | 1 | Main register has been written |
| burst_len | output | 5 | Decoded burst length, 0 when reserved |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| cas_latency | output | 3 | Decoded CAS latency, 0 when reserved |
| refresh_portion | output | 3 | Self-refresh array portion code |
| drive_strength | output | 2 | Output drive strength code |
| busy | output | 1 | Write-completion window active |
| protocol_error | output | 1 | Pulse: command seen during the window |
| write_reject | output | 1 | Pulse: write refused because banks were active |
| config_error | output | 1 | Sticky: reserved code or must-be-zero bit written |

## Verification
The bench builds the block with its defaults: a 13-bit address and a two-cycle hold window. These values put every must-be-zero bit and each code of the three decoded fields within reach. They also make the window short enough to hit its first edge, its last edge and the first free edge one after another. A behavioural model with integer state runs alongside and is compared on every falling edge. The stimulus sweeps all burst-length and latency codes, repeats writes back to back into the window, and issues writes with banks active and to the unused bank codes. It also raises err_clear together with a new error.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef struct packed {
    logic [2:0] lat_code;
    logic       order_il;
    logic [2:0] len_code;
  } main_cfg_t;

  typedef struct packed {
    logic [2:0] portion;
    logic [1:0] drive;
  } ext_cfg_t;

  localparam logic [1:0] TGT_MAIN = 2'b00;
  localparam logic [1:0] TGT_EXT  = 2'b10;

  localparam ext_cfg_t EXT_DEFAULT = '{portion: 3'b000, drive: 2'b01};

  function automatic logic [4:0] len_decode(input logic [2:0] code);
    case (code)
      3'b001:  len_decode = 5'd2;
      3'b010:  len_decode = 5'd4;
      3'b011:  len_decode = 5'd8;
      3'b100:  len_decode = 5'd16;
      default: len_decode = 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] lat_decode(input logic [2:0] code);
    case (code)
      3'b010:  lat_decode = 3'd2;
      3'b011:  lat_decode = 3'd3;
      default: lat_decode = 3'd0;
    endcase
  endfunction

  function automatic logic portion_reserved(input logic [2:0] code);
    portion_reserved = (code > 3'b010);
  endfunction

endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  output logic       any_cmd,
  output logic       wr_main,
  output logic       wr_ext
);
  import mrs_pkg::*;

  logic reg_write;

  always_comb begin
    any_cmd   = !cs_n && !(ras_n && cas_n && we_n);
    reg_write = !cs_n && !ras_n && !cas_n && !we_n;
    wr_main   = reg_write && (ba == TGT_MAIN);
    wr_ext    = reg_write && (ba == TGT_EXT);
  end

endmodule

// File: rtl/mrs_window.sv
module mrs_window #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic any_cmd,
  output logic busy,
  output logic protocol_error
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] remain_q;

  assign busy = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q       <= '0;
      protocol_error <= 1'b0;
    end else begin
      protocol_error <= busy && any_cmd;
      if (start && !busy)
        remain_q <= HOLD_LOAD;
      else if (busy)
        remain_q <= remain_q - 1'b1;
    end
  end

  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8

  AST_ERR_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cmd && !busy) |=> !protocol_error); // R8

endmodule

// File: rtl/mrs_regs.sv
module mrs_regs #(
  parameter int ADDR_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_main,
  input  logic                load_ext,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                err_clear,
  output mrs_pkg::main_cfg_t  main_q,
  output mrs_pkg::ext_cfg_t   ext_q,
  output logic                valid_q,
  output logic                config_error
);
  import mrs_pkg::*;

  localparam int FIELD_W = 7;
  localparam int HIGH_W  = ADDR_W - FIELD_W;

  logic [HIGH_W-1:0] high_bits;
  logic              main_bad;
  logic              ext_bad;
  logic              bad_write;

  assign high_bits = addr[ADDR_W-1:FIELD_W];

  always_comb begin
    main_bad  = (high_bits != '0)
             || (len_decode(addr[2:0]) == 5'd0)
             || (lat_decode(addr[6:4]) == 3'd0);
    ext_bad   = (high_bits != '0)
             || (addr[4:3] != 2'b00)
             || portion_reserved(addr[2:0]);
    bad_write = (load_main && main_bad) || (load_ext && ext_bad);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q       <= '0;
      ext_q        <= EXT_DEFAULT;
      valid_q      <= 1'b0;
      config_error <= 1'b0;
    end else begin
      if (load_main) begin
        main_q  <= '{lat_code: addr[6:4], order_il: addr[3], len_code: addr[2:0]};
        ext_q   <= EXT_DEFAULT;
        valid_q <= 1'b1;
      end else if (load_ext) begin
        ext_q <= '{portion: addr[2:0], drive: addr[6:5]};
      end
      if (bad_write)
        config_error <= 1'b1;
      else if (err_clear)
        config_error <= 1'b0;
    end
  end

  AST_EXT_DEFAULT_AFTER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    load_main |=> (ext_q == EXT_DEFAULT)); // R7

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error && !err_clear) |=> config_error); // R10

endmodule

// File: rtl/sdram_mode_ctl.sv
module sdram_mode_ctl #(
  parameter int ADDR_W   = 13,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              err_clear,
  output logic              mode_valid,
  output logic [4:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_latency,
  output logic [2:0]        refresh_portion,
  output logic [1:0]        drive_strength,
  output logic              busy,
  output logic              protocol_error,
  output logic              write_reject,
  output logic              config_error
);
  import mrs_pkg::*;

  logic      any_cmd;
  logic      wr_main;
  logic      wr_ext;
  logic      wr_any;
  logic      accept;
  main_cfg_t main_q;
  ext_cfg_t  ext_q;

  mrs_cmd_decode u_decode (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .any_cmd (any_cmd),
    .wr_main (wr_main),
    .wr_ext  (wr_ext)
  );

  assign wr_any = wr_main || wr_ext;
  assign accept = wr_any && !busy && banks_idle;

  mrs_window #(.HOLD_CYC(HOLD_CYC)) u_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (accept),
    .any_cmd        (any_cmd),
    .busy           (busy),
    .protocol_error (protocol_error)
  );

  mrs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_main    (wr_main && accept),
    .load_ext     (wr_ext && accept),
    .addr         (addr),
    .err_clear    (err_clear),
    .main_q       (main_q),
    .ext_q        (ext_q),
    .valid_q      (mode_valid),
    .config_error (config_error)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) write_reject <= 1'b0;
    else        write_reject <= wr_any && !busy && !banks_idle;
  end

  always_comb begin
    burst_len        = mode_valid ? len_decode(main_q.len_code) : 5'd0;
    cas_latency      = mode_valid ? lat_decode(main_q.lat_code) : 3'd0;
    burst_interleave = mode_valid && main_q.order_il;
    refresh_portion  = ext_q.portion;
    drive_strength   = ext_q.drive;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(main_q) && $stable(ext_q))); // R8

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !banks_idle) |=> ($stable(main_q) && $stable(ext_q) && $stable(mode_valid))); // R9

  AST_UNUSED_BANK_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_any) |=> !busy); // R1

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    write_reject |=> !write_reject || $past(wr_any && !banks_idle)); // R9

endmodule

// File: tb/test_sdram_mode_ctl.sv
module test_sdram_mode_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'b00;
  logic [AW-1:0] addr = '0;
  logic banks_idle = 1'b1;
  logic err_clear = 1'b0;

  logic mode_valid, burst_interleave, busy, protocol_error, write_reject, config_error;
  logic [4:0] burst_len;
  logic [2:0] cas_latency, refresh_portion;
  logic [1:0] drive_strength;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_ctl #(.ADDR_W(AW), .HOLD_CYC(2)) i_sdram_mode_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .banks_idle(banks_idle), .err_clear(err_clear),
    .mode_valid(mode_valid), .burst_len(burst_len), .burst_interleave(burst_interleave),
    .cas_latency(cas_latency), .refresh_portion(refresh_portion),
    .drive_strength(drive_strength), .busy(busy), .protocol_error(protocol_error),
    .write_reject(write_reject), .config_error(config_error)
  );

  // behavioural reference state
  int m_valid, m_len, m_il, m_lat, m_por, m_drv, m_cnt, m_perr, m_rej, m_cfg;

  always @(posedge clk) begin
    int cmd, wrt, tgt_ok, acc, bad, hi, code;
    if (!rst_n) begin
      m_valid = 0; m_len = 0; m_il = 0; m_lat = 0; m_por = 0; m_drv = 1;
      m_cnt = 0; m_perr = 0; m_rej = 0; m_cfg = 0;
    end else begin
      cmd    = (!cs_n && !(ras_n && cas_n && we_n));
      wrt    = (!cs_n && !ras_n && !cas_n && !we_n);
      tgt_ok = (ba == 2'b00 || ba == 2'b10);
      m_perr = (m_cnt > 0) && cmd;
      m_rej  = wrt && tgt_ok && (m_cnt == 0) && !banks_idle;
      acc    = wrt && tgt_ok && (m_cnt == 0) && banks_idle;
      hi     = int'(addr) / 128;
      bad    = 0;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (acc) begin
        m_cnt = 2;
        if (ba == 2'b00) begin
          code = int'(addr[2:0]);
          m_len = (code >= 1 && code <= 4) ? (1 << code) : 0;
          m_il  = int'(addr[3]);
          code = int'(addr[6:4]);
          m_lat = (code == 2 || code == 3) ? code : 0;
          m_valid = 1; m_por = 0; m_drv = 1;
          bad = (hi != 0) || (m_len == 0) || (m_lat == 0);
        end else begin
          m_por = int'(addr[2:0]);
          m_drv = int'(addr[6:5]);
          bad = (hi != 0) || (addr[4:3] != 2'b00) || (m_por > 2);
        end
      end
      if (bad) m_cfg = 1;
      else if (err_clear) m_cfg = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11", "mode_valid", int'(mode_valid), m_valid);
      chk("R2", "burst_len", int'(burst_len), m_valid ? m_len : 0);
      chk("R3", "burst_interleave", int'(burst_interleave), m_valid ? m_il : 0);
      chk("R4", "cas_latency", int'(cas_latency), m_valid ? m_lat : 0);
      chk("R5", "refresh_portion", int'(refresh_portion), m_por);
      chk("R5", "drive_strength", int'(drive_strength), m_drv);
      chk("R8", "busy", int'(busy), int'(m_cnt != 0));
      chk("R8", "protocol_error", int'(protocol_error), m_perr);
      chk("R9", "write_reject", int'(write_reject), m_rej);
      chk("R10", "config_error", int'(config_error), m_cfg);
    end
  end

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input int a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = AW'(a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    ba = 2'b00; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [3:0] WR  = 4'b0000;
  localparam logic [3:0] ACT = 4'b0011;
  localparam logic [3:0] RD  = 4'b0101;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    chk("R6", "reset drive_strength", int'(drive_strength), 1);
    chk("R6", "reset mode_valid", int'(mode_valid), 0);
    chk("R6", "reset busy", int'(busy), 0);
    idle(1);

    // R1 R2 R4: main write BL4 sequential CL3
    issue(WR, 2'b00, 'h032); idle(3);
    chk("R2", "burst_len after write", int'(burst_len), 4);
    chk("R4", "cas_latency after write", int'(cas_latency), 3);
    // R1 R5: extended write half portion, quarter drive
    issue(WR, 2'b10, 'h041); idle(3);
    chk("R5", "drive quarter", int'(drive_strength), 2);
    // R7 R3: main write resets extended register, interleave CL2 BL8
    issue(WR, 2'b00, 'h02B); idle(3);
    chk("R7", "drive default after main", int'(drive_strength), 1);
    chk("R3", "interleave", int'(burst_interleave), 1);

    // R8: commands inside the window are dropped, third edge accepted
    issue(WR, 2'b00, 'h032);
    issue(WR, 2'b10, 'h061);
    issue(ACT, 2'b01, 'h123);
    issue(WR, 2'b10, 'h062);
    idle(3);
    chk("R8", "write after window", int'(refresh_portion), 2);
    issue(WR, 2'b00, 'h032);
    issue(RD, 2'b00, 'h000);
    idle(3);

    // R1: unused bank codes
    issue(WR, 2'b01, 'h011); idle(3);
    issue(WR, 2'b11, 'h011); idle(3);
    // R9: banks active
    banks_idle = 1'b0;
    issue(WR, 2'b00, 'h023); idle(1);
    issue(WR, 2'b10, 'h001); idle(2);
    banks_idle = 1'b1;
    idle(1);

    // R10: reserved codes, must-be-zero bits, clear priority
    issue(WR, 2'b00, 'h010); idle(3);
    chk("R10", "config_error set", int'(config_error), 1);
    err_clear = 1'b1; idle(1); err_clear = 1'b0; idle(1);
    issue(WR, 2'b10, 'h018); idle(3);
    err_clear = 1'b1;
    issue(WR, 2'b00, 'h1032);
    err_clear = 1'b0;
    idle(3);
    chk("R10", "set wins over clear", int'(config_error), 1);
    err_clear = 1'b1; idle(1); err_clear = 1'b0;
    issue(WR, 2'b10, 'h007); idle(3);

    // R2 R4: sweep every length and latency code
    for (int l = 0; l < 8; l++) begin
      for (int c = 0; c < 8; c++) begin
        issue(WR, 2'b00, (c << 4) | ((l & 1) << 3) | l);
        idle(2);
      end
    end
    for (int p = 0; p < 8; p++) begin
      issue(WR, 2'b10, ((p & 3) << 5) | p);
      idle(2);
    end
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule